// File: doc/BRIEF.md
# Page-Mode Controller for Multiplexed-Address Asynchronous DRAM

This block sits between a simple host request port and an external asynchronous DRAM that takes its row and column addresses on one shared set of pins. Each host request carries a full word address, a direction flag and write data. The controller splits the address into an upper row half and a lower column half. It sends the row half with a falling row strobe and the column half with a falling column strobe. Read data comes back on a one-cycle response pulse, and responses arrive in request order.

After an access the row stays open. If the next request targets the same row, only the column strobe is cycled again. A request to a different row first closes the open row, then waits out the precharge time before the new row is opened. The row also closes once it has been open for a bounded time, or when a separate refresh scheduler asks for the memory. In that case the controller closes the row, waits out precharge and grants the memory until the request drops. Every timing interval is a parameter counted in clock cycles.

Writes are early: the write strobe and the write data are set up before the column strobe falls. Reads are late: the output enable goes low only after the column strobe has fallen. The data pins appear as a separate output, output enable and input, which a pad ring joins into one bidirectional bus.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is held, all four strobes (`mem_ras_n`, `mem_cas_n`, `mem_we_n`, `mem_oe_n`, active low) are high, `mem_dq_oe` is 0, `rsp_valid` and `ref_gnt` are 0, and `req_ready` is 1.
- R2: A request address is split into a row half `req_addr[ROW_W+COL_W-1:COL_W]` and a column half `req_addr[COL_W-1:0]`. The row half is on `mem_addr` when `mem_ras_n` falls, and the column half is on `mem_addr` when `mem_cas_n` falls. Data written to an address is returned by a later read of that address.
- R3: While a row is open, a request to the same row is served by a new `mem_cas_n` pulse alone. `mem_ras_n` stays low and does not fall again.
- R4: `mem_ras_n` stays high for at least `T_RP` cycles before it falls. It stays low for at least `T_RC-T_RP` cycles before it rises. Successive falls of `mem_ras_n` are at least `T_RC` cycles apart.
- R5: `mem_cas_n` falls only while `mem_ras_n` is low. Successive falls of `mem_cas_n` are at least `T_PC` cycles apart.
- R6: Read data is captured no earlier than `T_CAC` cycles after `mem_cas_n` fell and no earlier than `T_RAC` cycles after `mem_ras_n` fell.
- R7: For a write, `mem_we_n` is low and `mem_dq_oe` is 1 with the write data on `mem_dq_o` before `mem_cas_n` falls. Both are held until `mem_cas_n` rises.
- R8: For a read, `mem_oe_n` is still high when `mem_cas_n` falls and goes low afterwards. `mem_oe_n` and `mem_we_n` are never low together.
- R9: With no request pending, an open row is closed exactly `T_RAS_MAX` cycles after `mem_ras_n` fell.
- R10: While `ref_req` is high, no request is accepted. The open row is closed and, after precharge, `ref_gnt` rises with `mem_ras_n` and `mem_cas_n` high. Both strobes stay quiet until `ref_req` falls, and then `ref_gnt` falls.
- R11: Each read produces exactly one `rsp_valid` pulse, in request order. Writes produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row half on top |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request taken on this clock edge if valid |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | DATA_W | Read data |
| ref_req | input | 1 | Refresh scheduler asks for the memory |
| ref_gnt | output | 1 | Memory handed to the refresh scheduler |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed address pins |
| mem_dq_o | output | DATA_W | Write data toward the pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_i | input | DATA_W | Data from the pins |

## Verification
The bench targets several corner cases, each with a visible symptom if the design gets it wrong:
- A run of same-row accesses must add only one row opening. A controller that reopens the row on every access shows extra row-strobe falls.
- A change of row must respect precharge and the row cycle. A controller that skips this is caught by the memory model, which times every strobe edge.
- Read capture timing is tested with a model that drives inverted data until the column and row access times have both elapsed. A controller that samples one cycle early therefore returns corrupted words.
- The model checks that each column strobe carries the address the bench just issued. Swapped or misplaced address halves are reported even when the data round trip would still agree.
- Two further tests cover row closure. In the idle-timeout test the row must close after exactly the maximum open time. In the refresh test a request held during the grant must be refused while the strobes stay high.

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl #(
  parameter int ROW_W     = 4,
  parameter int COL_W     = 4,
  parameter int DATA_W    = 8,
  parameter int T_RCD     = 1,
  parameter int T_RAC     = 3,
  parameter int T_CAC     = 2,
  parameter int T_PC      = 4,
  parameter int T_RP      = 3,
  parameter int T_RC      = 6,
  parameter int T_RAS_MAX = 40
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  input  logic                                 req_write,
  input  logic [ROW_W+COL_W-1:0]               req_addr,
  input  logic [DATA_W-1:0]                    req_wdata,
  output logic                                 req_ready,
  output logic                                 rsp_valid,
  output logic [DATA_W-1:0]                    rsp_rdata,
  input  logic                                 ref_req,
  output logic                                 ref_gnt,
  output logic                                 mem_ras_n,
  output logic                                 mem_cas_n,
  output logic                                 mem_we_n,
  output logic                                 mem_oe_n,
  output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0] mem_addr,
  output logic [DATA_W-1:0]                    mem_dq_o,
  output logic                                 mem_dq_oe,
  input  logic [DATA_W-1:0]                    mem_dq_i
);

  localparam int MA_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int RAS_MIN = T_RC - T_RP;
  localparam int CAS_LO  = (T_CAC < 2) ? 2 : T_CAC;
  localparam int MAXT_A  = (T_RAS_MAX > T_RC) ? T_RAS_MAX : T_RC;
  localparam int MAXT_B  = (T_PC > T_RAC) ? T_PC : T_RAC;
  localparam int MAXT    = (MAXT_A > MAXT_B) ? MAXT_A : MAXT_B;
  localparam int AGE_W   = $clog2(MAXT + 2);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_RCD, S_COL, S_CAS, S_OPEN, S_REF} state_t;

  state_t             state;
  logic [ROW_W-1:0]   open_row, cur_row;
  logic [COL_W-1:0]   cur_col;
  logic               cur_write;
  logic [DATA_W-1:0]  cur_wdata;
  logic [AGE_W-1:0]   ras_age, cas_age, rp_age;

  wire [ROW_W-1:0] req_row = req_addr[ROW_W+COL_W-1:COL_W];
  wire [COL_W-1:0] req_col = req_addr[COL_W-1:0];

  wire hit        = (req_row == open_row);
  wire rp_ok      = int'(rp_age)  + 1 >= T_RP;
  wire rcd_ok     = int'(ras_age) + 1 >= T_RCD;
  wire rac_ok     = int'(ras_age) + 1 >= T_RAC;
  wire ras_min_ok = int'(ras_age) + 1 >= RAS_MIN;
  wire timeout    = int'(ras_age) + 1 >= T_RAS_MAX;
  wire pc_ok      = int'(cas_age) + 1 >= T_PC;
  wire cac_ok     = int'(cas_age) + 1 >= CAS_LO;
  wire close_now  = ras_min_ok && (ref_req || timeout);

  assign req_ready = !ref_req &&
                     ((state == S_IDLE) ||
                      (state == S_OPEN && !timeout && (hit || ras_min_ok)));

  function automatic logic [AGE_W-1:0] sat_inc(input logic [AGE_W-1:0] a);
    return (a == '1) ? a : a + 1'b1;
  endfunction

  logic [MA_W-1:0] ma;
  assign mem_addr = ma;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      mem_ras_n <= 1'b1;
      mem_cas_n <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      mem_dq_o  <= '0;
      ma        <= '0;
      open_row  <= '0;
      cur_row   <= '0;
      cur_col   <= '0;
      cur_write <= 1'b0;
      cur_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      ref_gnt   <= 1'b0;
      ras_age   <= '1;
      cas_age   <= '1;
      rp_age    <= '1;
    end else begin
      ras_age   <= sat_inc(ras_age);
      cas_age   <= sat_inc(cas_age);
      rp_age    <= sat_inc(rp_age);
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (ref_req) begin
            if (rp_ok) begin
              ref_gnt <= 1'b1;
              state   <= S_REF;
            end
          end else if (req_valid) begin
            cur_row   <= req_row;
            cur_col   <= req_col;
            cur_write <= req_write;
            cur_wdata <= req_wdata;
            ma        <= MA_W'(req_row);
            state     <= S_ROW;
          end
        end
        S_ROW: if (rp_ok) begin
          mem_ras_n <= 1'b0;
          ras_age   <= '0;
          open_row  <= cur_row;
          state     <= S_RCD;
        end
        S_RCD: if (rcd_ok) begin
          ma        <= MA_W'(cur_col);
          mem_we_n  <= !cur_write;
          mem_dq_oe <= cur_write;
          mem_dq_o  <= cur_wdata;
          state     <= S_COL;
        end
        S_COL: if (pc_ok) begin
          mem_cas_n <= 1'b0;
          cas_age   <= '0;
          state     <= S_CAS;
        end
        S_CAS: begin
          mem_oe_n <= cur_write;
          if (cac_ok && rac_ok) begin
            mem_cas_n <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            rsp_valid <= !cur_write;
            rsp_rdata <= mem_dq_i;
            state     <= S_OPEN;
          end
        end
        S_OPEN: begin
          if (close_now) begin
            mem_ras_n <= 1'b1;
            rp_age    <= '0;
            state     <= S_IDLE;
          end else if (req_valid && req_ready) begin
            cur_row   <= req_row;
            cur_col   <= req_col;
            cur_write <= req_write;
            cur_wdata <= req_wdata;
            if (hit) begin
              ma        <= MA_W'(req_col);
              mem_we_n  <= !req_write;
              mem_dq_oe <= req_write;
              mem_dq_o  <= req_wdata;
              state     <= S_COL;
            end else begin
              mem_ras_n <= 1'b1;
              rp_age    <= '0;
              ma        <= MA_W'(req_row);
              state     <= S_ROW;
            end
          end
        end
        S_REF: if (!ref_req) begin
          ref_gnt <= 1'b0;
          rp_age  <= '0;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_cas_inside_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cas_n |-> !mem_ras_n);
  assert_page_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cas_n) |-> (int'($past(cas_age)) + 1 >= T_PC));
  assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ras_n) |-> (int'($past(rp_age)) + 1 >= T_RP));
  assert_oe_we_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  assert_late_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cas_n) |-> mem_oe_n);
  assert_write_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);
  assert_grant_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (mem_ras_n && mem_cas_n));
  assert_rsp_after_cas_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_cas_n));

endmodule

// File: tb/test_dram_page_ctrl.sv
module test_dram_page_ctrl;

  localparam int ROW_W = 4, COL_W = 4, DATA_W = 8;
  localparam int T_RCD = 1, T_RAC = 3, T_CAC = 2, T_PC = 4, T_RP = 3, T_RC = 6, T_RAS_MAX = 40;
  localparam int AW = ROW_W + COL_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, ref_req = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0, mem_dq_i = '0;
  logic req_ready, rsp_valid, ref_gnt, mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DATA_W-1:0] rsp_rdata, mem_dq_o;
  logic [COL_W-1:0] mem_addr;

  always #10 clk = ~clk;

  dram_page_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
    .T_RAC(T_RAC), .T_CAC(T_CAC), .T_PC(T_PC), .T_RP(T_RP), .T_RC(T_RC),
    .T_RAS_MAX(T_RAS_MAX)) i_dram_page_ctrl (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata, .req_ready,
    .rsp_valid, .rsp_rdata, .ref_req, .ref_gnt, .mem_ras_n, .mem_cas_n,
    .mem_we_n, .mem_oe_n, .mem_addr, .mem_dq_o, .mem_dq_oe, .mem_dq_i);

  int n_chk = 0, n_fail = 0, n_reads = 0, n_rsp = 0, cyc = 0;
  logic [DATA_W-1:0] shadow [1<<AW];
  logic [DATA_W-1:0] mem [1<<AW];
  logic [DATA_W-1:0] exp_q [$];
  logic [AW-1:0] addr_q [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    finish_test();
  end

  // memory model
  logic m_ras_p = 1, m_cas_p = 1, m_oe_p = 1, have_fall = 0, have_rise = 0, have_cas = 0;
  logic [ROW_W-1:0] m_row = '0;
  logic [AW-1:0] m_a = '0;
  int ras_fall_c = 0, ras_rise_c = 0, cas_fall_c = 0, last_low = 0, ras_falls = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (m_ras_p && !mem_ras_n) begin
        if (have_fall) chk(cyc - ras_fall_c >= T_RC, "R4 row cycle", cyc - ras_fall_c, T_RC);
        if (have_rise) chk(cyc - ras_rise_c >= T_RP, "R4 precharge", cyc - ras_rise_c, T_RP);
        m_row = mem_addr[ROW_W-1:0];
        ras_fall_c = cyc; have_fall = 1; ras_falls++;
      end
      if (!m_ras_p && mem_ras_n) begin
        last_low = cyc - ras_fall_c;
        chk(last_low >= T_RC - T_RP, "R4 row low time", last_low, T_RC - T_RP);
        ras_rise_c = cyc; have_rise = 1;
      end
      if (m_cas_p && !mem_cas_n) begin
        chk(!mem_ras_n, "R5 cas inside ras", mem_ras_n, 0);
        if (have_cas) chk(cyc - cas_fall_c >= T_PC, "R5 page spacing", cyc - cas_fall_c, T_PC);
        chk(mem_oe_n, "R8 oe high at cas fall", mem_oe_n, 1);
        m_a = {m_row, mem_addr};
        if (addr_q.size() > 0) begin
          chk(m_a == addr_q[0], "R2 address halves", m_a, addr_q[0]);
          void'(addr_q.pop_front());
        end else chk(0, "R2 unexpected cas", 1, 0);
        if (!mem_we_n) begin
          chk(mem_dq_oe, "R7 write data driven", mem_dq_oe, 1);
          mem[m_a] = mem_dq_o;
        end
        cas_fall_c = cyc; have_cas = 1;
      end
      if (m_oe_p && !mem_oe_n) chk(mem_we_n, "R8 we high during read", mem_we_n, 1);
      m_ras_p = mem_ras_n; m_cas_p = mem_cas_n; m_oe_p = mem_oe_n;
      if (!mem_cas_n && !mem_oe_n && mem_we_n &&
          cyc - cas_fall_c >= T_CAC - 1 && cyc - ras_fall_c >= T_RAC - 1)
        mem_dq_i = mem[m_a];
      else
        mem_dq_i = ~mem[m_a];
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_rsp++;
      if (exp_q.size() == 0) chk(0, "R11 response without read", 1, 0);
      else begin
        chk(rsp_rdata == exp_q[0], "R6 read data", rsp_rdata, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic do_req(input bit wr, input int row, input int col, input int data);
    logic [AW-1:0] a;
    a = AW'((row << COL_W) | col);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = DATA_W'(data);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    addr_q.push_back(a);
    if (wr) shadow[a] = DATA_W'(data);
    else begin exp_q.push_back(shadow[a]); n_reads++; end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  initial begin
    int rf0, rsp0;
    for (int i = 0; i < (1<<AW); i++) begin shadow[i] = '0; mem[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ras_n && mem_cas_n, "R1 ras/cas high", {mem_ras_n, mem_cas_n}, 3);
    chk(mem_we_n && mem_oe_n, "R1 we/oe high", {mem_we_n, mem_oe_n}, 3);
    chk(!mem_dq_oe && !rsp_valid && !ref_gnt, "R1 quiet", {mem_dq_oe, rsp_valid, ref_gnt}, 0);
    chk(req_ready, "R1 ready", req_ready, 1);
    rst_n = 1;

    // R3 page of writes
    rf0 = ras_falls;
    for (int c = 0; c < 4; c++) do_req(1, 5, c, 8'h50 + c);
    repeat (8) @(negedge clk);
    chk(ras_falls - rf0 == 1, "R3 one row opening", ras_falls - rf0, 1);
    chk(!mem_ras_n, "R3 row held open", mem_ras_n, 0);

    // R2 R6 reads back
    for (int c = 3; c >= 0; c--) do_req(0, 5, c, 0);
    repeat (50) @(negedge clk);

    // R4 row changes
    rsp0 = n_rsp;
    do_req(1, 9, 2, 8'hAA);
    repeat (12) @(negedge clk);
    chk(n_rsp == rsp0, "R11 write gives no response", n_rsp, rsp0);
    do_req(0, 5, 1, 0);
    do_req(0, 9, 2, 0);
    do_req(1, 5, 1, 8'h3C);
    do_req(0, 5, 1, 0);
    do_req(0, 0, 15, 0);
    do_req(1, 15, 0, 8'hC3);
    do_req(0, 15, 0, 0);

    // R9 idle timeout
    repeat (60) @(negedge clk);
    do_req(0, 7, 7, 0);
    repeat (60) @(negedge clk);
    chk(mem_ras_n, "R9 row closed", mem_ras_n, 1);
    chk(last_low == T_RAS_MAX, "R9 open time", last_low, T_RAS_MAX);

    // R10 refresh grant
    do_req(1, 2, 4, 8'h77);
    repeat (2) @(negedge clk);
    ref_req = 1;
    for (int k = 0; k < 40 && !ref_gnt; k++) @(negedge clk);
    chk(ref_gnt, "R10 grant given", ref_gnt, 1);
    chk(mem_ras_n && mem_cas_n, "R10 strobes high at grant", {mem_ras_n, mem_cas_n}, 3);
    req_valid = 1; req_write = 0; req_addr = AW'((2 << COL_W) | 4);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!req_ready, "R10 request refused", req_ready, 0);
      chk(mem_ras_n && mem_cas_n && ref_gnt, "R10 quiet during grant",
          {mem_ras_n, mem_cas_n, ref_gnt}, 7);
    end
    req_valid = 0;
    ref_req = 0;
    repeat (2) @(negedge clk);
    chk(!ref_gnt, "R10 grant released", ref_gnt, 0);
    do_req(0, 2, 4, 0);

    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);
    chk(n_rsp == n_reads, "R11 response count", n_rsp, n_reads);
    finish_test();
  end

endmodule